// File: doc/BRIEF.md
# Double-Length Shift and Normalize Unit

This unit shifts the 48-bit value formed by two 24-bit accumulators. The high word A sits above the low word B. It offers three kinds of operation. A straight shift moves the pair arithmetically to the right or logically to the left. A rotate moves all 48 bits around a ring in either direction. A normalize shifts left until the bit below the sign differs from the sign, and it lowers an index word X by one for each position moved. The shift count reaches the unit already resolved, as a 6-bit value.

After a one-cycle start strobe, the unit captures A, B, X and the operation settings. It then handles up to two bit positions per clock. It raises a one-cycle done strobe together with the final A, B and X. An overflow pulse comes with done when a straight left shift has pushed a bit past the sign that did not match it. The result words stay on the outputs until the next accepted start. In this text the MSB of each word is its bit 0, so "A bit 1" is the bit just below the sign of A.

Top module: `dls_shift_norm`

## Requirements
- R1: A right straight shift (method 2'b00, left_i=0) of N positions gives {A,B} arithmetically shifted right by N. The sign of A is copied into every vacated position, and bits leaving the low end of B are lost.
- R2: A left straight shift (method 2'b00, left_i=1) of N gives {A,B} shifted left by N. Zeros enter at the low end of B, and bits leaving the sign end of A are lost.
- R3: overflow_o pulses with done_o only after a left straight shift. It pulses when the N+1 top bits of the original pair are not all equal, counting zeros beyond the low end of B. Every other operation gives no overflow.
- R4: Method 2'b10 rotates all 48 bits around a ring by N positions, to the left or right as left_i selects.
- R5: Method 2'b01 with left_i=1 normalizes. Each step shifts the pair left by one with a zero entering B and lowers X by one, modulo 2^24. Steps continue until A bit 1 differs from the A sign or N steps are done. An already normalized pair takes zero steps.
- R6: Method 2'b11, and method 2'b01 with left_i=0, act as a straight shift in the selected direction. X is returned unchanged by every operation other than normalize.
- R7: Let k be the number of positions moved. done_o is high for exactly one cycle, during the clock cycle after the ceil(k/2)-th rising edge that follows the edge at which start was taken. An operation therefore occupies 2 + ceil(k/2) cycles, counting the start cycle.
- R8: A start that arrives while an operation is in progress is ignored, including one that arrives in the done cycle. The result words keep their values until a start is accepted.
- R9: A count of zero finishes in the fixed two cycles. It leaves A, B and X equal to their inputs and gives no overflow.
- R10: After reset, done_o and overflow_o are low and the result words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| left_i | input | 1 | 1 = left, 0 = right |
| method_i | input | 2 | 00 shift, 10 rotate, 01 normalize |
| count_i | input | 6 | Shift count N, 0 to 63 |
| a_i | input | 24 | High word A |
| b_i | input | 24 | Low word B |
| x_i | input | 24 | Index word X |
| a_o | output | 24 | Resulting A |
| b_o | output | 24 | Resulting B |
| x_o | output | 24 | Resulting X |
| overflow_o | output | 1 | Overflow pulse, with done |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The inputs are driven on the falling edge with start raised, and the bench then counts rising edges until done is seen at a falling edge. That count must equal one plus ceil(k/2). For normalize, k is the shift count the bench derives from the pair's redundant sign bits; for every other operation, k is N. The result words and the overflow pulse are read in that same done cycle. At the next falling edge the bench confirms that done has dropped. Starts issued in the middle of an operation or during the done cycle are checked afterwards at the outputs: the result must still belong to the first operation, and no new done may appear.

// File: rtl/dls_pkg.sv
package dls_pkg;

  typedef enum logic [1:0] {
    MD_SHIFT = 2'd0,
    MD_ROT   = 2'd1,
    MD_NORM  = 2'd2
  } dls_mode_e;

  // Method code to operating mode; normalize exists only leftward.
  function automatic dls_mode_e dls_decode(input logic [1:0] method, input logic left);
    dls_mode_e m;
    case (method)
      2'b10:   m = MD_ROT;
      2'b01:   m = left ? MD_NORM : MD_SHIFT;
      default: m = MD_SHIFT;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/dls_lane.sv
module dls_lane
  import dls_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int X_W    = 24,
  localparam int PAIR_W = 2 * WORD_W
) (
  input  dls_mode_e         mode_i,
  input  logic              left_i,
  input  logic              en_i,
  input  logic [PAIR_W-1:0] pair_i,
  input  logic [X_W-1:0]    x_i,
  output logic [PAIR_W-1:0] pair_o,
  output logic [X_W-1:0]    x_o,
  output logic              step_o,
  output logic              ovf_o
);

  // One-position move of the pair for a given mode and direction.
  function automatic logic [PAIR_W-1:0] move1(input logic [PAIR_W-1:0] p,
                                               input dls_mode_e m, input logic lft);
    logic [PAIR_W-1:0] r;
    if (lft) begin
      r = (m == MD_ROT) ? {p[PAIR_W-2:0], p[PAIR_W-1]} : {p[PAIR_W-2:0], 1'b0};
    end else begin
      r = (m == MD_ROT) ? {p[0], p[PAIR_W-1:1]} : {p[PAIR_W-1], p[PAIR_W-1:1]};
    end
    return r;
  endfunction

  logic sign_split;
  assign sign_split = pair_i[PAIR_W-1] ^ pair_i[PAIR_W-2];

  assign step_o = en_i && !((mode_i == MD_NORM) && sign_split);
  assign pair_o = step_o ? move1(pair_i, mode_i, left_i) : pair_i;
  assign x_o    = (step_o && mode_i == MD_NORM) ? x_i - X_W'(1) : x_i;
  assign ovf_o  = step_o && (mode_i == MD_SHIFT) && left_i && sign_split;

endmodule

// File: rtl/dls_ctrl.sv
module dls_ctrl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] n_done_i,
  input  logic             halt_i,
  output logic             load_o,
  output logic             run_o,
  output logic             fin_o,
  output logic [CNT_W-1:0] rem_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_next;

  assign load_o   = start_i && (st_q == ST_IDLE);
  assign run_o    = (st_q == ST_RUN);
  assign fin_o    = (st_q == ST_FIN);
  assign rem_o    = rem_q;
  assign rem_next = rem_q - n_done_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (load_o) begin
          rem_q <= count_i;
          st_q  <= (count_i == '0 || skip_i) ? ST_FIN : ST_RUN;
        end
        ST_RUN: begin
          rem_q <= rem_next;
          if (rem_next == '0 || halt_i) st_q <= ST_FIN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R7: completion strobe lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |=> !fin_o);

  // R7: every busy cycle moves at least one position, so time tracks shifts
  a_r7_run_progress: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (n_done_i != '0));

endmodule

// File: rtl/dls_shift_norm.sv
module dls_shift_norm
  import dls_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int CNT_W  = 6,
  parameter int LANES  = 2,
  localparam int PAIR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              left_i,
  input  logic [1:0]        method_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] x_i,
  output logic [WORD_W-1:0] a_o,
  output logic [WORD_W-1:0] b_o,
  output logic [WORD_W-1:0] x_o,
  output logic              overflow_o,
  output logic              done_o
);

  logic [PAIR_W-1:0] pair_q;
  logic [WORD_W-1:0] x_q;
  logic              ovf_q;
  logic              left_q;
  dls_mode_e         mode_q;

  logic              load, run, fin, halt, skip;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  n_done;
  dls_mode_e         mode_in;

  logic [PAIR_W-1:0] pair_c [LANES+1];
  logic [WORD_W-1:0] x_c    [LANES+1];
  logic [LANES-1:0]  lane_en, lane_step, lane_ovf;

  assign mode_in   = dls_decode(method_i, left_i);
  assign skip      = (mode_in == MD_NORM) && (a_i[WORD_W-1] ^ a_i[WORD_W-2]);
  assign pair_c[0] = pair_q;
  assign x_c[0]    = x_q;

  for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
    if (gi == 0) begin : g_first
      assign lane_en[gi] = run && (rem > CNT_W'(gi));
    end else begin : g_next
      assign lane_en[gi] = lane_step[gi-1] && (rem > CNT_W'(gi));
    end
    dls_lane #(.WORD_W(WORD_W), .X_W(WORD_W)) u_lane (
      .mode_i (mode_q),
      .left_i (left_q),
      .en_i   (lane_en[gi]),
      .pair_i (pair_c[gi]),
      .x_i    (x_c[gi]),
      .pair_o (pair_c[gi+1]),
      .x_o    (x_c[gi+1]),
      .step_o (lane_step[gi]),
      .ovf_o  (lane_ovf[gi])
    );
  end

  always_comb begin
    n_done = '0;
    for (int k = 0; k < LANES; k++) n_done = n_done + CNT_W'(lane_step[k]);
  end

  assign halt = (mode_q == MD_NORM) &&
                (pair_c[LANES][PAIR_W-1] ^ pair_c[LANES][PAIR_W-2]);

  dls_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .count_i  (count_i),
    .skip_i   (skip),
    .n_done_i (n_done),
    .halt_i   (halt),
    .load_o   (load),
    .run_o    (run),
    .fin_o    (fin),
    .rem_o    (rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= '0;
      x_q    <= '0;
      ovf_q  <= 1'b0;
      left_q <= 1'b0;
      mode_q <= MD_SHIFT;
    end else if (load) begin
      pair_q <= {a_i, b_i};
      x_q    <= x_i;
      ovf_q  <= 1'b0;
      left_q <= left_i;
      mode_q <= mode_in;
    end else if (run) begin
      pair_q <= pair_c[LANES];
      x_q    <= x_c[LANES];
      ovf_q  <= ovf_q | (|lane_ovf);
    end
  end

  assign a_o        = pair_q[PAIR_W-1:WORD_W];
  assign b_o        = pair_q[WORD_W-1:0];
  assign x_o        = x_q;
  assign done_o     = fin;
  assign overflow_o = fin && ovf_q;

  // R1: right straight shift never alters the sign of A
  a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MD_SHIFT && !left_q) |-> (pair_c[LANES][PAIR_W-1] == pair_q[PAIR_W-1]));

  // R4: the ring keeps its population of ones
  a_r4_ring_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MD_ROT) |-> ($countones(pair_c[LANES]) == $countones(pair_q)));

  // R5: X falls by exactly the positions moved this cycle
  a_r5_x_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MD_NORM) |-> (x_c[LANES] == x_q - WORD_W'(n_done)));

  // R3: normalize and rotate never report overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && mode_q != MD_SHIFT) |-> !overflow_o);

  // R6: X untouched outside normalize
  a_r6_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q != MD_NORM) |-> (x_c[LANES] == x_q));

  // R8: a start in the done cycle does not reload the results
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && start_i) |=> (a_o == $past(a_o) && b_o == $past(b_o) && x_o == $past(x_o)));

endmodule

// File: tb/tb_dls_shift_norm.sv
module tb_dls_shift_norm;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        left_i = 1'b0;
  logic [1:0]  method_i = 2'b00;
  logic [5:0]  count_i = '0;
  logic [23:0] a_i = '0, b_i = '0, x_i = '0;
  logic [23:0] a_o, b_o, x_o;
  logic        overflow_o, done_o;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dls_shift_norm dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .left_i(left_i),
    .method_i(method_i), .count_i(count_i), .a_i(a_i), .b_i(b_i), .x_i(x_i),
    .a_o(a_o), .b_o(b_o), .x_o(x_o), .overflow_o(overflow_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [47:0] pats [8] = '{48'h800000_000001, 48'h000000_000001, 48'h7FFFFF_FFFFFF,
                            48'hFFFFFF_FFFFFF, 48'h123456_789ABC, 48'hC00000_000000,
                            48'h000000_000000, 48'h003000_00F000};

  // Redundant sign bits of a pair; unbounded (64) for zero.
  function automatic int norm_room(input logic [47:0] p);
    int lead = 0;
    if (p == '0) return 64;
    for (int i = 47; i >= 0; i--) begin
      if (p[i] != p[47]) break;
      lead++;
    end
    return lead - 1;
  endfunction

  task automatic run_op(input logic lft, input logic [1:0] meth, input int n,
                        input logic [47:0] p, input logic [23:0] x);
    logic [47:0] ep;
    logic [23:0] ex;
    logic        eov;
    logic [95:0] win, mask;
    int k, edges, r;
    string tag;
    ex = x; eov = 1'b0; k = n;
    r = n % 48;
    if (meth == 2'b10) begin
      tag = "R4";
      if (lft) begin
        win = {p, p} << r;
        ep = win[95:48];
      end else begin
        win = {p, p} >> r;
        ep = win[47:0];
      end
    end else if (meth == 2'b01 && lft) begin
      tag = "R5";
      k = (norm_room(p) < n) ? norm_room(p) : n;
      ep = p << k;
      ex = x - 24'(k);
    end else begin
      tag = (meth == 2'b00) ? (lft ? "R2" : "R1") : "R6";
      if (lft) begin
        ep = p << n;
        win = {p, 48'b0};
        mask = ~((96'd1 << (95 - n)) - 96'd1);
        eov = !((win & mask) == '0 || (win & mask) == mask);
      end else begin
        ep = 48'($signed(p) >>> n);
      end
    end
    if (n == 0) tag = "R9";
    @(negedge clk);
    left_i = lft; method_i = meth; count_i = 6'(n);
    a_i = p[47:24]; b_i = p[23:0]; x_i = x; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    edges = 1;
    while (!done_o && edges < 80) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    check("R7 latency", 72'(edges), 72'(1 + (k + 1) / 2));
    check(tag, {a_o, b_o, x_o}, {ep, ex});
    check("R3 overflow", 72'(overflow_o), 72'(eov));
    @(negedge clk);
    check("R7 single done", 72'(done_o), 72'd0);
  endtask

  initial begin
    #(20 * 190000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] ha, hb;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {a_o, b_o, x_o}, 72'd0);
    check("R10 reset flags", 72'({done_o, overflow_o}), 72'd0);
    rst_n = 1'b1;

    for (int pi = 0; pi < 8; pi++) begin
      for (int n = 0; n < 64; n++) begin
        run_op(1'b0, 2'b00, n, pats[pi], 24'h000100);
        run_op(1'b1, 2'b00, n, pats[pi], 24'h000100);
        run_op(1'b1, 2'b10, n, pats[pi], 24'h000100);
        run_op(1'b0, 2'b10, n, pats[pi], 24'h000100);
        run_op(1'b1, 2'b01, n, pats[pi], 24'h000005);
        run_op(1'b0, 2'b01, n, pats[pi], 24'h000100);
        run_op(1'b1, 2'b11, n, pats[pi], 24'h000100);
      end
    end

    // R8: start mid-run is ignored
    @(negedge clk);
    left_i = 1'b1; method_i = 2'b00; count_i = 6'd20;
    a_i = 24'h000012; b_i = 24'h345678; x_i = 24'h1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    a_i = 24'hFFFFFF; b_i = 24'hFFFFFF; left_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check("R8 busy start", {a_o, b_o, x_o}, {48'h000012_345678 << 20, 24'h1});
    ha = a_o; hb = b_o;
    // R8: start during the done cycle is ignored
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check("R8 no restart", 72'(done_o), 72'd0);
    end
    check("R8 held", {a_o, b_o, x_o}, {ha, hb, 24'h1});

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule